// File: doc/BRIEF.md
# Audio Serial Transmitter

This block turns a stream of 16-bit stereo sample pairs into a three-wire serial audio output. The three wires are a bit clock, a word select that marks the left and right halves of each frame, and a serial data line. The bit clock comes from dividing the system clock. The number of bit clocks in each channel slot is programmable. The data can be placed in a slot in one of three ways: standard I2S (one bit clock of delay after the word-select edge), left justified, or right justified. In right-justified mode, the leading bit clocks of a slot are padded with either zeros or copies of the sign bit.

Samples enter through a valid/ready port backed by a holding register that stores one pair. The ready signal also acts as the block's request for the next pair. It goes high again as soon as the held pair moves into the shifters at the start of a frame, so the next pair can be delivered while the current frame is still being sent. A channel mode can blank either channel or both. A change of mode is applied only at the next slot boundary. Slot length, alignment and padding are sampled once per frame, when the left slot begins. If no pair is waiting when a frame begins, the frame is sent as silence and a sticky underrun flag is raised.

Top module: `audio_ser_tx`

## Requirements
- R1: `ser_bclk` stays high for `cfg_half`+1 system clock cycles and then low for `cfg_half`+1 cycles. `ser_ws` and `ser_sd` change only on the system clock edge at which `ser_bclk` falls.
- R2: `ser_ws` is 0 for the left slot and 1 for the right slot. The left slot is sent first after reset. Each slot lasts `cfg_slot`+1 bit clocks, sampled at the start of each left slot. Slot positions are counted from 0 at the word-select edge.
- R3: For `cfg_align` 0 or 3 (I2S), position 0 outputs 0. Sample bit 15 appears at position 1 and the following bits come MSB first. Positions after bit 0 output 0, and a slot too short for the whole sample truncates it.
- R4: For `cfg_align` 1 (left justified), sample bit 15 appears at position 0, MSB first. Positions after bit 0 output 0.
- R5: For `cfg_align` 2 (right justified), bit 0 falls on the last position of the slot. Each leading position before bit 15 outputs sample bit 15 when `cfg_sext` is 1, and 0 when `cfg_sext` is 0.
- R6: If `cfg_align` is 2 and `cfg_slot` is below 17 at the start of a frame, that frame uses 18-bit-clock slots and `cfg_err` is 1. In every other frame `cfg_err` is 0.
- R7: `cfg_chmode` 0 sends both channels. A value of 1 sends zeros in the left slot and data in the right slot. A value of 2 sends data in the left slot and zeros in the right slot. A value of 3 sends zeros in both slots.
- R8: A `cfg_chmode` change made in the middle of a slot does not affect that slot. It takes effect from the next slot onward.
- R9: `in_ready` is 1 exactly when the holding register is empty. A pair is taken when `in_valid` and `in_ready` are both 1 on a clock edge. The held pair moves into the shifters at the start of the next frame, which sets `in_ready` again.
- R10: If the holding register is empty when a frame begins, both slots of that frame carry zeros and `underrun` becomes 1 and stays 1 until reset.
- R11: While `rst_n` is low, the outputs are: `ser_bclk`, `ser_ws`, `ser_sd`, `underrun` and `cfg_err` all 0, and `in_ready` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half | input | DIV_W | Bit-clock half period minus one, in system clocks |
| cfg_align | input | 2 | Alignment: 0/3 I2S, 1 left, 2 right justified |
| cfg_slot | input | SLOT_W | Bit clocks per slot minus one |
| cfg_sext | input | 1 | Right-justified padding: 1 sign copies, 0 zeros |
| cfg_chmode | input | 2 | Channel mode: 0 stereo, 1 right only, 2 left only, 3 mute |
| in_valid | input | 1 | Sample pair offered |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| in_ready | output | 1 | Holding register empty; request for next pair |
| ser_bclk | output | 1 | Bit clock |
| ser_ws | output | 1 | Word select, 0 left, 1 right |
| ser_sd | output | 1 | Serial data, changes on bit-clock fall |
| underrun | output | 1 | Sticky: a frame began with no pair held |
| cfg_err | output | 1 | Current frame's right-justified slot was clamped |

## Verification
The bench rebuilds every slot from the serial pins and compares it with a pattern derived from the queued samples. It targets these failure modes:
- An off-by-one in the I2S delay or in right-justified placement would shift the whole word by one bit.
- Wrong padding would show up as a sign-extended negative sample arriving with zeros in its leading bits.
- A missing clamp would shorten the slot to the programmed 6 bit clocks.
- A channel mode applied immediately, rather than at the slot boundary, would blank or unblank the tail of the slot in progress. The bench changes the mode in the middle of both left and right slots to catch this.
- Starving the input checks that a silent frame is sent and that the underrun flag latches.
- A short I2S slot checks that the sample is truncated rather than spilling into the next slot.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int SAMPLE_W = 16;
    localparam int SLOT_W   = 5;

    typedef enum logic [1:0] {
        ALIGN_I2S   = 2'd0,
        ALIGN_LEFT  = 2'd1,
        ALIGN_RIGHT = 2'd2,
        ALIGN_ALT   = 2'd3
    } align_e;
endpackage

// File: rtl/atx_bclk_div.sv
module atx_bclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half,
    output logic             bclk,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
    } div_t;

    div_t q, d;
    logic term;

    always_comb begin
        d    = q;
        term = (q.cnt >= half);
        if (term) begin
            d.cnt  = '0;
            d.bclk = ~q.bclk;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bclk      = q.bclk;
    assign fall_tick = term & q.bclk;

    // R1
    fall_only_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> !bclk);
endmodule

// File: rtl/atx_bit_pick.sv
module atx_bit_pick #(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 5
) (
    input  logic [SAMPLE_W-1:0] word,
    input  logic [SLOT_W-1:0]   pos,
    input  logic [SLOT_W-1:0]   last,
    input  atx_pkg::align_e     align,
    input  logic                sext,
    output logic                bit_o
);
    int p;
    int k;
    logic [SAMPLE_W-1:0] sh;

    always_comb begin
        p     = int'(pos);
        k     = int'(last) - p;
        sh    = '0;
        bit_o = 1'b0;
        unique case (align)
            atx_pkg::ALIGN_LEFT: begin
                if (p < SAMPLE_W) begin
                    sh    = word >> (SAMPLE_W - 1 - p);
                    bit_o = sh[0];
                end
            end
            atx_pkg::ALIGN_RIGHT: begin
                if (k >= 0 && k < SAMPLE_W) begin
                    sh    = word >> k;
                    bit_o = sh[0];
                end else begin
                    bit_o = sext & word[SAMPLE_W-1];
                end
            end
            default: begin
                if (p >= 1 && p <= SAMPLE_W) begin
                    sh    = word >> (SAMPLE_W - p);
                    bit_o = sh[0];
                end
            end
        endcase
    end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
    parameter int DIV_W    = 8,
    parameter int SAMPLE_W = atx_pkg::SAMPLE_W,
    parameter int SLOT_W   = atx_pkg::SLOT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    cfg_half,
    input  logic [1:0]          cfg_align,
    input  logic [SLOT_W-1:0]   cfg_slot,
    input  logic                cfg_sext,
    input  logic [1:0]          cfg_chmode,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                in_ready,
    output logic                ser_bclk,
    output logic                ser_ws,
    output logic                ser_sd,
    output logic                underrun,
    output logic                cfg_err
);
    import atx_pkg::*;

    localparam logic [SLOT_W-1:0] RJ_MIN_LAST = SLOT_W'(SAMPLE_W + 1);

    typedef struct packed {
        logic                ch;
        logic                first;
        logic [SLOT_W-1:0]   pos;
        logic [SLOT_W-1:0]   slot_last;
        align_e              align;
        logic                sext;
        logic [1:0]          mode;
        logic [SAMPLE_W-1:0] cur_l;
        logic [SAMPLE_W-1:0] cur_r;
        logic [SAMPLE_W-1:0] hold_l;
        logic [SAMPLE_W-1:0] hold_r;
        logic                hold_full;
        logic                ws;
        logic                underrun;
        logic                err;
    } tx_t;

    tx_t  q, d;
    logic sd_q, sd_d;
    logic fall_tick;
    logic pick_bit;
    logic slot_end;
    logic accept;
    logic [SAMPLE_W-1:0] slot_word;

    atx_bclk_div #(.DIV_W(DIV_W)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .half      (cfg_half),
        .bclk      (ser_bclk),
        .fall_tick (fall_tick)
    );

    always_comb begin
        d        = q;
        accept   = in_valid & ~q.hold_full;
        slot_end = q.first || (q.pos == q.slot_last);
        if (fall_tick) begin
            if (slot_end) begin
                d.pos   = '0;
                d.ch    = q.first ? 1'b0 : ~q.ch;
                d.first = 1'b0;
                d.mode  = cfg_chmode;
                if (!d.ch) begin
                    d.align = align_e'(cfg_align);
                    d.sext  = cfg_sext;
                    if (align_e'(cfg_align) == ALIGN_RIGHT && cfg_slot < RJ_MIN_LAST) begin
                        d.slot_last = RJ_MIN_LAST;
                        d.err       = 1'b1;
                    end else begin
                        d.slot_last = cfg_slot;
                        d.err       = 1'b0;
                    end
                    if (q.hold_full) begin
                        d.cur_l     = q.hold_l;
                        d.cur_r     = q.hold_r;
                        d.hold_full = 1'b0;
                    end else begin
                        d.cur_l    = '0;
                        d.cur_r    = '0;
                        d.underrun = 1'b1;
                    end
                end
            end else begin
                d.pos = q.pos + 1'b1;
            end
            d.ws = d.ch;
        end
        if (accept) begin
            d.hold_l    = in_left;
            d.hold_r    = in_right;
            d.hold_full = 1'b1;
        end
    end

    always_comb begin
        if (d.ch) slot_word = d.mode[1] ? '0 : d.cur_r;
        else      slot_word = d.mode[0] ? '0 : d.cur_l;
    end

    atx_bit_pick #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) i_pick (
        .word  (slot_word),
        .pos   (d.pos),
        .last  (d.slot_last),
        .align (d.align),
        .sext  (d.sext),
        .bit_o (pick_bit)
    );

    always_comb sd_d = fall_tick ? pick_bit : sd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.ch    <= 1'b1;
            q.first <= 1'b1;
            sd_q    <= 1'b0;
        end else begin
            q    <= d;
            sd_q <= sd_d;
        end
    end

    assign in_ready = ~q.hold_full;
    assign ser_ws   = q.ws;
    assign ser_sd   = sd_q;
    assign underrun = q.underrun;
    assign cfg_err  = q.err;

    // R1
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_ws != $past(ser_ws)) |-> ($past(ser_bclk) && !ser_bclk));
    // R1
    sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_sd != $past(ser_sd)) |-> ($past(ser_bclk) && !ser_bclk));
    // R2
    pos_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pos <= q.slot_last);
    // R6
    err_right_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (q.align == ALIGN_RIGHT && q.slot_last == RJ_MIN_LAST));
    // R9
    hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold_full && !fall_tick) |=> (q.hold_full && $stable(q.hold_l) && $stable(q.hold_r)));
    // R10
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: tb/test_audio_ser_tx.sv
`timescale 1ns/1ps
module test_audio_ser_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_half = 8'd0;
    logic [1:0]  cfg_align = 2'd0;
    logic [4:0]  cfg_slot = 5'd17;
    logic        cfg_sext = 1'b0;
    logic [1:0]  cfg_chmode = 2'd0;
    logic        in_valid = 1'b0;
    logic [15:0] in_left = '0;
    logic [15:0] in_right = '0;
    logic        in_ready, ser_bclk, ser_ws, ser_sd, underrun, cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q[$];

    audio_ser_tx i_audio_ser_tx (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_align(cfg_align),
        .cfg_slot(cfg_slot), .cfg_sext(cfg_sext), .cfg_chmode(cfg_chmode),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .in_ready(in_ready), .ser_bclk(ser_bclk), .ser_ws(ser_ws),
        .ser_sd(ser_sd), .underrun(underrun), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    task automatic check(input logic ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [15:0] w, input int p, input int len,
                                     input logic [1:0] al, input logic sx);
        int lead;
        if (al == 2'd1) return (p < 16) ? w[15-p] : 1'b0;
        if (al == 2'd2) begin
            lead = len - 16;
            return (p < lead) ? (sx & w[15]) : w[15-(p-lead)];
        end
        return (p >= 1 && p <= 16) ? w[16-p] : 1'b0;
    endfunction

    function automatic int exp_len(input logic [1:0] al, input logic [4:0] s);
        if (al == 2'd2 && s < 5'd17) return 18;
        return int'(s) + 1;
    endfunction

    task automatic driver(input int n, input logic [15:0] seed);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_left  = seed ^ 16'(i * 16'h1357);
            in_right = ~seed ^ 16'(i * 16'h2469);
            while (!in_ready) @(negedge clk);
            exp_q.push_back({in_left, in_right});
            @(posedge clk); #1;
            // R9: taken pair fills the holding register
            check(in_ready == 1'b0, "R9 ready after accept", 64'(in_ready), 64'd0);
        end
        in_valid = 1'b0;
    endtask

    task automatic monitor(input int n_slots, input string req);
        logic [31:0] got, exp;
        int cnt, len, done;
        logic cur_ws, sx;
        logic [1:0] al, md;
        logic [15:0] wl, wr, w;
        done = 0; len = 0; al = 0; sx = 0; wl = 0; wr = 0;
        @(negedge ser_bclk);
        @(posedge ser_bclk); #1;
        cur_ws = ser_ws;
        got = '0; cnt = 0;
        md = cfg_chmode;
        while (done < n_slots) begin
            if (cnt == 0) begin
                md = cfg_chmode;
                if (!cur_ws) begin
                    al  = cfg_align; sx = cfg_sext;
                    len = exp_len(cfg_align, cfg_slot);
                    if (exp_q.size() > 0) {wl, wr} = exp_q.pop_front();
                    else begin wl = '0; wr = '0; end
                    // R6
                    check(cfg_err == (cfg_align == 2'd2 && cfg_slot < 5'd17),
                          "R6 cfg_err", 64'(cfg_err), 64'(cfg_align == 2'd2 && cfg_slot < 5'd17));
                end
                // R7 channel blanking
                w = cur_ws ? (md[1] ? 16'd0 : wr) : (md[0] ? 16'd0 : wl);
            end
            if (cnt < 32) got[cnt] = ser_sd;
            cnt++;
            @(posedge ser_bclk); #1;
            if (ser_ws != cur_ws) begin
                exp = '0;
                for (int p = 0; p < len && p < 32; p++) exp[p] = exp_bit(w, p, len, al, sx);
                // R2 slot length, R3/R4/R5 placement, R7/R8 mode
                check(cnt == len && got == exp, req, {got, 32'(cnt)}, {exp, 32'(len)});
                done++;
                cur_ws = ser_ws;
                got = '0; cnt = 0;
            end
        end
    endtask

    task automatic apply_reset(input logic [7:0] h, input logic [1:0] al, input logic [4:0] s,
                               input logic sx, input logic [1:0] md, input logic chk);
        rst_n = 1'b0;
        cfg_half = h; cfg_align = al; cfg_slot = s; cfg_sext = sx; cfg_chmode = md;
        exp_q.delete();
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (chk) begin
            // R11
            check({ser_bclk, ser_ws, ser_sd, underrun, cfg_err, in_ready} == 6'b000001,
                  "R11 reset outputs", 64'({ser_bclk, ser_ws, ser_sd, underrun, cfg_err, in_ready}), 64'h1);
        end
        rst_n = 1'b1;
    endtask

    task automatic run(input int n, input logic [15:0] seed, input string req);
        fork
            driver(n, seed);
            monitor(2 * (n + 1), req);
        join
    endtask

    task automatic measure_bclk(input int h);
        int c;
        @(posedge ser_bclk);
        c = 0;
        do begin @(posedge clk); #1; c++; end while (ser_bclk);
        // R1
        check(c == h + 1, "R1 bclk high time", 64'(c), 64'(h + 1));
    endtask

    initial begin
        #(20 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R3 I2S stereo, 18-clock slots; R10 starvation at the end
        apply_reset(8'd0, 2'd0, 5'd17, 1'b0, 2'd0, 1'b1);
        fork
            begin
                driver(3, 16'hA5C3);
                // R10: pairs still held, no starvation yet
                check(underrun == 1'b0, "R10 no early underrun", 64'(underrun), 64'd0);
            end
            monitor(8, "R3 I2S slot");
        join
        // R10
        check(underrun == 1'b1, "R10 underrun sticky", 64'(underrun), 64'd1);

        // R4 left justified, 20-clock slots, divider half=1
        apply_reset(8'd1, 2'd1, 5'd19, 1'b0, 2'd0, 1'b0);
        run(3, 16'h3C81, "R4 left justified slot");
        measure_bclk(1);

        // R5 right justified with sign copies, negative and positive samples
        apply_reset(8'd0, 2'd2, 5'd19, 1'b1, 2'd0, 1'b0);
        run(3, 16'h9F0E, "R5 right justified sext");

        // R6 clamp to 18 with zero padding
        apply_reset(8'd0, 2'd2, 5'd5, 1'b0, 2'd0, 1'b0);
        run(2, 16'hC731, "R6 clamped right justified");

        // R8 mode changes mid-slot, R7 all channel modes
        apply_reset(8'd0, 2'd1, 5'd17, 1'b0, 2'd0, 1'b0);
        fork
            run(4, 16'h5AA5, "R8 R7 mode change");
            begin
                @(posedge ser_ws); repeat (4) @(posedge ser_bclk); #1 cfg_chmode = 2'd2;
                @(negedge ser_ws); repeat (4) @(posedge ser_bclk); #1 cfg_chmode = 2'd1;
                @(posedge ser_ws); repeat (4) @(posedge ser_bclk); #1 cfg_chmode = 2'd3;
            end
        join

        // R3 short I2S slot truncates
        apply_reset(8'd0, 2'd3, 5'd9, 1'b0, 2'd0, 1'b0);
        run(2, 16'hE11D, "R3 short I2S slot");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule